// File: doc/BRIEF.md
# Clock Frequency Integrity Monitor

This block watches two clocks against an internal RC reference clock, which is also the clock of its register interface. Each monitored clock gets a free-running edge counter in its own domain. The reference domain closes a fixed window of `WINDOW` reference cycles and asks, through a toggle handshake, for the edge count of the window that just ended.

The crystal oscillator fails when it runs slower than the reference divided by a power of two. The PLL fails when its count falls outside a low/high window. Each check runs only while the mode controller reports that source as valid. The PLL check also needs its enable bit. A failure sets a sticky pending bit. The configuration then routes each event class to a reset request, a safe-mode request or an interrupt request.

A one-shot frequency meter counts reference cycles across a programmed number of oscillator cycles. Software uses the result to trim the reference against the crystal.

Top module: `clk_integrity_mon`

## Requirements
- R1: After reset the registers read: CTRL (addr 0) = 0x0003, LOW (addr 1) = 0, HIGH (addr 2) = 0x0FFF, STATUS (addr 3) = 0, PERIOD (addr 4) = 0 and RESULT (addr 5) = 0. All three request outputs are low.
- R2: While osc_valid is high, STATUS[0] is set when a window counts fewer oscillator edges than WINDOW >> CTRL[1:0]. A slower oscillator than reference/2^CTRL[1:0] therefore fails, while a faster one does not.
- R3: While osc_valid is low, the oscillator check sets nothing.
- R4: While the PLL check is active, STATUS[1] is set when the window count is below LOW[11:0], and STATUS[2] is set when it is above HIGH[11:0]. A count inside the window sets neither bit.
- R5: The PLL check is active only when CTRL[2] and pll_valid are both high.
- R6: Pending bits STATUS[3:0] stay set until software writes 1 to the bit at addr 3.
- R7: The oscillator event (STATUS[0]) routes through CTRL[3] (reset-disable) and CTRL[5] (alternate). The PLL events (STATUS[2:1]) route through CTRL[4] and CTRL[6]. A reset-disable bit of 0 raises reset_req. Otherwise the alternate bit at 0 raises safe_req, and at 1 raises irq.
- R8: A monitored clock that delivers no count within a window is treated as a zero count for that window.
- R9: Writing 1 to bit 0 of addr 5 starts the meter. STATUS[4] reads 1 while the meter runs. When it finishes, STATUS[3] is set and RESULT holds about PERIOD × f_ref / f_osc reference cycles, plus a few cycles of synchronizer delay.
- R10: Register reads return data on reg_rdata one reference cycle after the read is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Internal RC reference clock; also the register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_clk | input | 1 | Crystal oscillator clock under supervision |
| pll_clk | input | 1 | PLL output clock under supervision |
| osc_valid | input | 1 | Mode controller reports the oscillator stable |
| pll_valid | input | 1 | Mode controller reports the PLL locked |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, one cycle after the read |
| reset_req | output | 1 | Reset request to the reset controller |
| safe_req | output | 1 | Safe-mode request to the mode controller |
| irq | output | 1 | Interrupt request |

## Verification
A register read answers one reference cycle later. The scoreboard monitor therefore pops each expected item two nanoseconds after the clock edge that follows the read.

A change of clock frequency, validity or threshold shows in a pending bit within about two windows: one window to count, and up to one more for the synchronizer handshake. The bench first waits three windows and clears the stale pending bits. It then waits three more windows before it reads STATUS or looks at the request outputs.

Meter results carry a synchronizer offset of a few cycles, so they are compared against a range rather than a single value. Request outputs follow the pending bits in the same cycle.

// File: rtl/clk_integrity_mon.sv
module clk_integrity_mon #(
  parameter int WINDOW = 256,
  parameter int CW     = 12,
  parameter int DW     = 16,
  parameter int MPW    = 10
) (
  input  logic          ref_clk,
  input  logic          rst_n,
  input  logic          osc_clk,
  input  logic          pll_clk,
  input  logic          osc_valid,
  input  logic          pll_valid,
  input  logic          reg_sel,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          reset_req,
  output logic          safe_req,
  output logic          irq
);
  localparam int WIN_W = $clog2(WINDOW);

  logic [1:0]    div_sel;
  logic          pll_en, rd_osc, rd_pll, alt_osc, alt_pll;
  logic [CW-1:0] lo_thr, hi_thr;
  logic [2:0]    pend;
  logic [MPW-1:0] m_per;
  logic [DW-1:0] m_res;
  logic          m_busy, m_done, m_start_t;

  wire wr_en  = reg_sel & reg_wr;
  wire rd_en  = reg_sel & ~reg_wr;
  wire wr_st  = wr_en && reg_addr == 3'd3;
  wire go_req = wr_en && reg_addr == 3'd5 && reg_wdata[0] && !m_busy;

  // window timer
  logic [WIN_W-1:0] wcnt;
  wire win_end = (wcnt == WIN_W'(WINDOW - 1));
  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) wcnt <= '0;
    else        wcnt <= win_end ? '0 : wcnt + 1'b1;

  // per-clock edge counting with toggle handshake
  logic [1:0]      mclk, act, ack_new, smp_ok, stall;
  logic [2*CW-1:0] hold_bus;
  assign mclk = {pll_clk, osc_clk};
  assign act  = {pll_valid & pll_en, osc_valid};

  for (genvar g = 0; g < 2; g++) begin : g_ch
    logic [2:0]    rq_s, ak_s;
    logic [CW-1:0] cnt, hold;
    logic          ack, rq_t, bsy, prm;
    wire           anew = ak_s[2] ^ ak_s[1];
    wire           bz   = bsy & ~anew;

    always_ff @(posedge mclk[g] or negedge rst_n)
      if (!rst_n) begin
        rq_s <= '0; cnt <= '0; hold <= '0; ack <= 1'b0;
      end else begin
        rq_s <= {rq_s[1:0], rq_t};
        if (rq_s[2] ^ rq_s[1]) begin
          hold <= cnt;
          cnt  <= CW'(1);
          ack  <= ~ack;
        end else if (cnt != '1) cnt <= cnt + 1'b1;
      end

    always_ff @(posedge ref_clk or negedge rst_n)
      if (!rst_n) begin
        ak_s <= '0; rq_t <= 1'b0; bsy <= 1'b0; prm <= 1'b0;
      end else begin
        ak_s <= {ak_s[1:0], ack};
        if (anew) bsy <= 1'b0;
        if (anew && act[g]) prm <= 1'b1;
        if (win_end) begin
          if (!bz) begin
            rq_t <= ~rq_t;
            bsy  <= 1'b1;
          end else prm <= 1'b0;
        end
        if (!act[g]) prm <= 1'b0;
      end

    assign ack_new[g] = anew;
    assign smp_ok[g]  = anew & prm & act[g];
    assign stall[g]   = win_end & bz & act[g];
    assign hold_bus[g*CW +: CW] = hold;
  end

  wire [CW-1:0] osc_cnt = hold_bus[0 +: CW];
  wire [CW-1:0] pll_cnt = hold_bus[CW +: CW];
  wire [CW-1:0] osc_thr = CW'(WINDOW) >> div_sel;

  logic [2:0] ev;
  assign ev[0] = (smp_ok[0] && osc_cnt < osc_thr) || stall[0];
  assign ev[1] = (smp_ok[1] && pll_cnt < lo_thr) || (stall[1] && lo_thr != '0);
  assign ev[2] = smp_ok[1] && pll_cnt > hi_thr;

  // frequency meter, oscillator side
  logic [2:0]     ms_s;
  logic [MPW-1:0] m_dn;
  logic           m_run, m_done_t;
  always_ff @(posedge osc_clk or negedge rst_n)
    if (!rst_n) begin
      ms_s <= '0; m_dn <= '0; m_run <= 1'b0; m_done_t <= 1'b0;
    end else begin
      ms_s <= {ms_s[1:0], m_start_t};
      if (ms_s[2] ^ ms_s[1]) begin
        m_dn  <= m_per;
        m_run <= 1'b1;
      end else if (m_run) begin
        if (m_dn <= MPW'(1)) begin
          m_run    <= 1'b0;
          m_done_t <= ~m_done_t;
        end else m_dn <= m_dn - 1'b1;
      end
    end

  logic [2:0] md_s;
  wire m_fin = md_s[2] ^ md_s[1];

  // register file, pending bits and meter, reference side
  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      div_sel <= 2'd3; pll_en <= 1'b0; rd_osc <= 1'b0; rd_pll <= 1'b0;
      alt_osc <= 1'b0; alt_pll <= 1'b0; lo_thr <= '0; hi_thr <= '1;
      pend <= '0; m_per <= '0; m_res <= '0; m_busy <= 1'b0; m_done <= 1'b0;
      m_start_t <= 1'b0; md_s <= '0; reg_rdata <= '0;
    end else begin
      md_s <= {md_s[1:0], m_done_t};
      if (wr_en) begin
        case (reg_addr)
          3'd0: {alt_pll, alt_osc, rd_pll, rd_osc, pll_en, div_sel} <= reg_wdata[6:0];
          3'd1: lo_thr <= reg_wdata[CW-1:0];
          3'd2: hi_thr <= reg_wdata[CW-1:0];
          3'd4: if (!m_busy) m_per <= reg_wdata[MPW-1:0];
          default: ;
        endcase
      end
      pend <= (pend & ~(wr_st ? reg_wdata[2:0] : 3'b000)) | ev;
      if (wr_st && reg_wdata[3]) m_done <= 1'b0;
      if (go_req) begin
        m_start_t <= ~m_start_t;
        m_busy    <= 1'b1;
        m_done    <= 1'b0;
        m_res     <= '0;
      end else if (m_busy) begin
        if (m_fin) begin
          m_busy <= 1'b0;
          m_done <= 1'b1;
        end else if (m_res != '1) m_res <= m_res + 1'b1;
      end
      if (rd_en) begin
        case (reg_addr)
          3'd0: reg_rdata <= DW'({alt_pll, alt_osc, rd_pll, rd_osc, pll_en, div_sel});
          3'd1: reg_rdata <= DW'(lo_thr);
          3'd2: reg_rdata <= DW'(hi_thr);
          3'd3: reg_rdata <= DW'({m_busy, m_done, pend});
          3'd4: reg_rdata <= DW'(m_per);
          3'd5: reg_rdata <= m_res;
          default: reg_rdata <= '0;
        endcase
      end
    end

  // event routing
  wire osc_p = pend[0];
  wire pll_p = |pend[2:1];
  assign reset_req = (osc_p & ~rd_osc) | (pll_p & ~rd_pll);
  assign safe_req  = (osc_p & rd_osc & ~alt_osc) | (pll_p & rd_pll & ~alt_pll);
  assign irq       = (osc_p & rd_osc & alt_osc) | (pll_p & rd_pll & alt_pll);

  p_osc_gate_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(pend[0]) |-> $past(osc_valid));
  p_pll_gate_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(|pend[2:1]) |-> $past(pll_valid && pll_en));
  p_sticky_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (pend[0] && !(wr_st && reg_wdata[0])) |=> pend[0]);
  p_idle_out_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (pend == 3'b000) |-> !(reset_req || safe_req || irq));
  p_one_route_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (pend == 3'b001) |-> $countones({reset_req, safe_req, irq}) == 1);
  p_meter_done_r9: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $fell(m_busy) |-> m_done);
endmodule

// File: tb/tb_clk_integrity_mon.sv
`timescale 1ns/1ps
module tb_clk_integrity_mon;
  logic ref_clk = 0, rst_n = 0, osc_clk = 0, pll_clk = 0;
  logic osc_valid = 0, pll_valid = 0;
  logic reg_sel = 0, reg_wr = 0;
  logic [2:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic reset_req, safe_req, irq;

  real osc_half = 20.0, pll_half = 4.0;
  int n_chk = 0, n_bad = 0;
  int q_lo[$], q_hi[$], q_mask[$];
  string q_tag[$];

  clk_integrity_mon dut (.*);

  always #10 ref_clk = ~ref_clk;
  initial forever begin
    if (osc_half == 0.0) #10; else begin #(osc_half); osc_clk = ~osc_clk; end
  end
  initial forever begin
    if (pll_half == 0.0) #10; else begin #(pll_half); pll_clk = ~pll_clk; end
  end

  task automatic wr(input int a, input int d);
    @(negedge ref_clk);
    reg_sel = 1; reg_wr = 1; reg_addr = 3'(a); reg_wdata = 16'(d);
    @(negedge ref_clk);
    reg_sel = 0; reg_wr = 0;
  endtask

  task automatic rd(input int a, input int mask, input int lo, input int hi, input string tag);
    @(negedge ref_clk);
    reg_sel = 1; reg_wr = 0; reg_addr = 3'(a);
    q_lo.push_back(lo); q_hi.push_back(hi); q_mask.push_back(mask); q_tag.push_back(tag);
    @(negedge ref_clk);
    reg_sel = 0;
  endtask

  initial forever begin
    bit take;
    @(posedge ref_clk);
    take = reg_sel && !reg_wr;
    #2;
    if (take && q_tag.size() > 0) begin
      int v, lo, hi;
      string t;
      lo = q_lo.pop_front(); hi = q_hi.pop_front(); t = q_tag.pop_front();
      v = int'(reg_rdata) & q_mask.pop_front();
      n_chk++;
      if (v < lo || v > hi) begin
        n_bad++;
        $display("FAIL %s: got 0x%0h expected 0x%0h..0x%0h", t, v, lo, hi);
      end
    end
  end

  task automatic chk_out(input bit r, input bit s, input bit i, input string tag);
    @(negedge ref_clk);
    n_chk++;
    if ({reset_req, safe_req, irq} != {r, s, i}) begin
      n_bad++;
      $display("FAIL %s: got rst/safe/irq %b%b%b expected %b%b%b", tag,
               reset_req, safe_req, irq, r, s, i);
    end
  endtask

  task automatic settle();
    repeat (3 * 256) @(posedge ref_clk);
  endtask

  task automatic clear_settle();
    settle();
    wr(3, 16'h000F);
    settle();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge ref_clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge ref_clk);
    rst_n = 1;
    // R1 reset state
    rd(0, 16'hFFFF, 16'h0003, 16'h0003, "R1 ctrl");
    rd(1, 16'hFFFF, 0, 0, "R1 low");
    rd(2, 16'hFFFF, 16'h0FFF, 16'h0FFF, "R1 high");
    rd(3, 16'hFFFF, 0, 0, "R1 status");
    rd(4, 16'hFFFF, 0, 0, "R1 period");
    rd(5, 16'hFFFF, 0, 0, "R1 result");
    chk_out(0, 0, 0, "R1 outputs");

    // R2 fast oscillator passes at the default divider
    osc_valid = 1; osc_half = 20.0;
    clear_settle();
    rd(3, 16'h7, 0, 0, "R2 fast osc");
    chk_out(0, 0, 0, "R2 fast osc outputs");

    // R2 slow oscillator fails, default route is reset (R7)
    osc_half = 200.0;
    clear_settle();
    rd(3, 16'h7, 1, 1, "R2 slow osc");
    chk_out(1, 0, 0, "R7 reset route");

    // R3 invalid oscillator is not checked; R6 clear
    osc_valid = 0;
    clear_settle();
    rd(3, 16'h7, 0, 0, "R3 osc invalid");
    chk_out(0, 0, 0, "R6 cleared outputs");

    // R2 divider: 12.5 MHz passes at /8, fails at /2
    osc_valid = 1; osc_half = 40.0;
    clear_settle();
    rd(3, 16'h7, 0, 0, "R2 div3 pass");
    wr(0, 16'h0001);
    clear_settle();
    rd(3, 16'h7, 1, 1, "R2 div1 fail");
    osc_valid = 0;
    settle();
    rd(3, 16'h7, 1, 1, "R6 sticky");
    wr(3, 16'h0001);
    rd(3, 16'h7, 0, 0, "R6 w1c");

    // R7 alternate routes
    wr(0, 16'h0009);
    osc_valid = 1;
    settle();
    chk_out(0, 1, 0, "R7 safe route");
    wr(0, 16'h0029);
    chk_out(0, 0, 1, "R7 irq route");
    osc_valid = 0;
    wr(3, 16'h000F);

    // R8 stopped oscillator
    wr(0, 16'h0003);
    osc_half = 0.0; osc_valid = 1;
    clear_settle();
    rd(3, 16'h7, 1, 1, "R8 stopped osc");
    osc_valid = 0; osc_half = 20.0;
    clear_settle();
    rd(3, 16'h7, 0, 0, "R8 recovered");

    // PLL window 0x200..0x300; 8 ns -> 640, 5 ns -> 1024, 16 ns -> 320
    wr(1, 16'h0200); wr(2, 16'h0300);
    rd(1, 16'hFFFF, 16'h0200, 16'h0200, "R4 low thr");
    pll_valid = 1; pll_half = 2.5;
    clear_settle();
    rd(3, 16'h7, 0, 0, "R5 pll disabled");
    wr(0, 16'h0007);
    clear_settle();
    rd(3, 16'h7, 4, 4, "R4 pll high");
    chk_out(1, 0, 0, "R7 pll reset route");
    pll_half = 4.0;
    clear_settle();
    rd(3, 16'h7, 0, 0, "R4 pll in window");
    pll_half = 8.0;
    clear_settle();
    rd(3, 16'h7, 2, 2, "R4 pll low");
    pll_valid = 0;
    clear_settle();
    rd(3, 16'h7, 0, 0, "R5 pll invalid");
    wr(0, 16'h0057);
    pll_valid = 1;
    settle();
    chk_out(0, 0, 1, "R7 pll irq route");
    wr(0, 16'h0017);
    chk_out(0, 1, 0, "R7 pll safe route");
    pll_valid = 0;
    wr(0, 16'h0003);
    wr(3, 16'h000F);

    // R9 meter: 50 osc cycles of 40 ns = 100 ref cycles plus sync delay
    osc_half = 20.0;
    settle();
    wr(4, 50);
    rd(4, 16'hFFFF, 50, 50, "R9 period");
    wr(5, 1);
    rd(3, 16'h18, 16'h10, 16'h10, "R9 busy");
    repeat (300) @(posedge ref_clk);
    rd(3, 16'h18, 16'h08, 16'h08, "R9 done");
    rd(5, 16'hFFFF, 98, 116, "R9 result");
    wr(3, 16'h0008);
    rd(3, 16'h18, 0, 0, "R9 done cleared");
    rd(0, 16'hFFFF, 16'h0003, 16'h0003, "R10 ctrl readback");

    repeat (4) @(posedge ref_clk);
    summary();
  end
endmodule